// File: doc/BRIEF.md
# Indirect BAR access window in configuration space

This block holds a small capability structure in a device's configuration space through which a host can reach memory behind a BAR using nothing but configuration cycles. Software programs a BAR selector, a byte offset and a transfer length, then touches a 4-byte data window. A configuration write to the window first lands in the window and then goes out to the BAR space. A configuration read of the window first fetches bytes from the BAR space into the window and then returns the dword.

Configuration accesses arrive on a dword-wide port with byte enables. The requester holds its request until the block raises a one-cycle completion. Back-side transfers leave on a request/acknowledge memory port. Each transfer carries a size code, an address aligned down to its size, byte enables and lane-steered data. Only the lengths 1, 2 and 4 produce a transfer. The BAR decoder and the memory behind it are outside the block.

Top module: `cfgwin_top`

## Requirements
- R1: After reset, the selector, offset, length and window fields all read zero, `cfg_done_o` is low and `mem_req_o` is low.
- R2: The capability occupies dwords CAP_BASE (selector, byte 0 only; bytes 1 to 3 read zero), CAP_BASE+1 (offset), CAP_BASE+2 (length) and CAP_BASE+3 (data window). Each byte of the selector, offset, length and window fields is written only when its byte enable is set.
- R3: An access to a dword outside the capability reads zero, changes nothing and makes no back-side transfer. `cfg_done_o` pulses on the first cycle after the request is accepted.
- R4: A window write with a valid length stores the written bytes first. It then issues exactly one back-side write (`mem_we_o`=1) that carries the new window contents.
- R5: A window read with a valid length issues exactly one back-side read. Window bytes 0 to length-1 are replaced by the fetched bytes, the other window bytes keep their value, and the returned `cfg_rdata_o` is the updated window.
- R6: When the length is not 1, 2 or 4 (including any value above 4), a window access makes no back-side transfer and completes like a plain register access.
- R7: The back-side address is offset AND NOT (length-1). `mem_size_o` is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R8: Lanes are little-endian. With lane L = address bits [1:0], `mem_be_o` holds length ones shifted left by L. Window byte i travels on lane L+i in both directions.
- R9: `cfg_done_o` stays low while a back-side transfer is outstanding and rises on the cycle after `mem_ack_i`. Request fields stay stable until the acknowledge.
- R10: `mem_bar_o` carries the programmed selector value during a transfer.
- R11: A window dword access overlaps the window only when at least one byte enable is set. With no enable set, nothing changes and no transfer is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Configuration request, held until `cfg_done_o` |
| cfg_we_i | input | 1 | 1 = write, 0 = read |
| cfg_addr_i | input | ADDR_W | Dword address in configuration space |
| cfg_be_i | input | 4 | Byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, valid while `cfg_done_o` is high |
| cfg_done_o | output | 1 | One-cycle completion; low means not ready |
| mem_req_o | output | 1 | Back-side request, held until acknowledge |
| mem_we_o | output | 1 | Back-side direction, 1 = write |
| mem_bar_o | output | BAR_W | Selected BAR |
| mem_addr_o | output | 32 | Aligned byte address |
| mem_size_o | output | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_be_o | output | 4 | Lane byte enables |
| mem_wdata_o | output | 32 | Lane-steered write data |
| mem_rdata_i | input | 32 | Read data, lane-aligned, sampled with acknowledge |
| mem_ack_i | input | 1 | Back-side acknowledge |

## Verification
A request accepted on one clock edge completes one cycle later when no transfer is needed. This covers out-of-range addresses, an unsupported length and a window access with no byte enables. With a transfer, `mem_req_o` rises one cycle after acceptance, and `cfg_done_o` follows one cycle after the acknowledge: 2 + L cycles in total for an acknowledge delayed by L cycles. The bench counts falling edges from the request to the first sight of completion and compares that count exactly with this figure, with L varied from 0 to 5. Transfer fields and read data are sampled on that same falling edge.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int unsigned NB = 4;
  localparam int unsigned DW = 8 * NB;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } win_state_e;
endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned CAP_BASE = 8,
  parameter int unsigned BAR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              fill_en_i,
  input  logic [NB-1:0]     fill_mask_i,
  input  logic [DW-1:0]     fill_data_i,
  output logic              win_hit_o,
  output logic [BAR_W-1:0]  bar_o,
  output logic [DW-1:0]     off_o,
  output logic [DW-1:0]     len_o,
  output logic [DW-1:0]     win_o,
  output logic [DW-1:0]     rdata_o
);
  localparam logic [ADDR_W-1:0] A_BAR = ADDR_W'(CAP_BASE);
  localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(CAP_BASE + 1);
  localparam logic [ADDR_W-1:0] A_LEN = ADDR_W'(CAP_BASE + 2);
  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(CAP_BASE + 3);

  logic sel_bar, sel_off, sel_len, sel_win;
  logic [NB-1:0][7:0] off_q, len_q, win_q;
  logic [BAR_W-1:0]   bar_q;

  assign sel_bar = (addr_i == A_BAR);
  assign sel_off = (addr_i == A_OFF);
  assign sel_len = (addr_i == A_LEN);
  assign sel_win = (addr_i == A_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_q <= '0;
      off_q <= '0;
      len_q <= '0;
      win_q <= '0;
    end else begin
      if (wr_en_i && sel_bar && be_i[0]) bar_q <= wdata_i[BAR_W-1:0];
      for (int b = 0; b < NB; b++) begin
        if (wr_en_i && be_i[b]) begin
          if (sel_off) off_q[b] <= wdata_i[8*b +: 8];
          if (sel_len) len_q[b] <= wdata_i[8*b +: 8];
          if (sel_win) win_q[b] <= wdata_i[8*b +: 8];
        end
        // back-side fill: only bytes 0..len-1
        if (fill_en_i && fill_mask_i[b]) win_q[b] <= fill_data_i[8*b +: 8];
      end
    end
  end

  assign win_hit_o = sel_win && (|be_i);
  assign bar_o     = bar_q;
  assign off_o     = off_q;
  assign len_o     = len_q;
  assign win_o     = win_q;

  always_comb begin
    rdata_o = '0;
    if (sel_bar) rdata_o = {{(DW-BAR_W){1'b0}}, bar_q};
    if (sel_off) rdata_o = off_q;
    if (sel_len) rdata_o = len_q;
    if (sel_win) rdata_o = win_q;
  end

  p_win_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !fill_en_i) |=> $stable(win_o));
  p_len_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i) |=> $stable(len_o) && $stable(off_o));
endmodule

// File: rtl/cfgwin_lane.sv
module cfgwin_lane
  import cfgwin_pkg::*;
(
  input  logic [DW-1:0] off_i,
  input  logic [DW-1:0] len_i,
  input  logic [DW-1:0] win_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          len_ok_o,
  output xfer_size_e    size_o,
  output logic [DW-1:0] addr_o,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] wdata_o,
  output logic [NB-1:0] fill_mask_o,
  output logic [DW-1:0] fill_data_o
);
  logic [NB-1:0] mask;
  logic [1:0]    lane;

  always_comb begin
    len_ok_o = (len_i == 32'd1) || (len_i == 32'd2) || (len_i == 32'd4);
    unique case (len_i)
      32'd1:   begin size_o = SZ_BYTE; mask = 4'b0001; end
      32'd2:   begin size_o = SZ_HALF; mask = 4'b0011; end
      default: begin size_o = SZ_WORD; mask = 4'b1111; end
    endcase
  end

  assign addr_o      = off_i & ~(len_i - 32'd1);
  assign lane        = addr_o[1:0];
  assign be_o        = mask << lane;
  assign fill_mask_o = mask;

  // little-endian steering: window byte i <-> lane (lane + i)
  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [1:0] src;
    logic [1:0] dst;
    assign src = 2'(i) - lane;
    assign dst = 2'(i) + lane;
    assign wdata_o[8*i +: 8]     = win_i[8*src +: 8];
    assign fill_data_o[8*i +: 8] = mem_rdata_i[8*dst +: 8];
  end
endmodule

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_req_i,
  input  logic cfg_we_i,
  input  logic win_hit_i,
  input  logic len_ok_i,
  input  logic mem_ack_i,
  output logic wr_en_o,
  output logic fill_en_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic cfg_done_o
);
  win_state_e state_q, state_d;
  logic       we_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cfg_req_i) state_d = (win_hit_i && len_ok_i) ? ST_XFER : ST_DONE;
      ST_XFER: if (mem_ack_i) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cfg_req_i) we_q <= cfg_we_i;
    end
  end

  assign wr_en_o    = (state_q == ST_IDLE) && cfg_req_i && cfg_we_i;
  assign fill_en_o  = (state_q == ST_XFER) && mem_ack_i && !we_q;
  assign mem_req_o  = (state_q == ST_XFER);
  assign mem_we_o   = we_q;
  assign cfg_done_o = (state_q == ST_DONE);

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o);
  p_done_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> (cfg_done_o && !mem_req_o));
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |=> !cfg_done_o);
  p_no_done_in_xfer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_done_o && mem_req_o));
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
  import cfgwin_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned CAP_BASE = 8,
  parameter int unsigned BAR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_req_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BAR_W-1:0]  mem_bar_o,
  output logic [31:0]       mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i
);
  logic          wr_en, fill_en, win_hit, len_ok;
  logic [NB-1:0] fill_mask;
  logic [DW-1:0] fill_data, off, len, win;
  xfer_size_e    size;

  cfgwin_regs #(
    .ADDR_W  (ADDR_W),
    .CAP_BASE(CAP_BASE),
    .BAR_W   (BAR_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .addr_i     (cfg_addr_i),
    .be_i       (cfg_be_i),
    .wdata_i    (cfg_wdata_i),
    .fill_en_i  (fill_en),
    .fill_mask_i(fill_mask),
    .fill_data_i(fill_data),
    .win_hit_o  (win_hit),
    .bar_o      (mem_bar_o),
    .off_o      (off),
    .len_o      (len),
    .win_o      (win),
    .rdata_o    (cfg_rdata_o)
  );

  cfgwin_lane u_lane (
    .off_i      (off),
    .len_i      (len),
    .win_i      (win),
    .mem_rdata_i(mem_rdata_i),
    .len_ok_o   (len_ok),
    .size_o     (size),
    .addr_o     (mem_addr_o),
    .be_o       (mem_be_o),
    .wdata_o    (mem_wdata_o),
    .fill_mask_o(fill_mask),
    .fill_data_o(fill_data)
  );

  cfgwin_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_req_i (cfg_req_i),
    .cfg_we_i  (cfg_we_i),
    .win_hit_i (win_hit),
    .len_ok_i  (len_ok),
    .mem_ack_i (mem_ack_i),
    .wr_en_o   (wr_en),
    .fill_en_o (fill_en),
    .mem_req_o (mem_req_o),
    .mem_we_o  (mem_we_o),
    .cfg_done_o(cfg_done_o)
  );

  assign mem_size_o = size;

  p_len_filter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (len == 32'd1 || len == 32'd2 || len == 32'd4));
  p_be_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == (1 << mem_size_o)));
  p_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_addr_o & ((32'd1 << mem_size_o) - 32'd1)) == 32'd0));
  p_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |->
      ($stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_be_o) && $stable(mem_bar_o)));
endmodule

// File: tb/sim_cfgwin_top.sv
`timescale 1ns/1ps
module sim_cfgwin_top;
  localparam int ADDR_W = 6;
  localparam logic [5:0] A_BAR = 6'd8, A_OFF = 6'd9, A_LEN = 6'd10, A_WIN = 6'd11;

  // table: window write after programming length/offset
  localparam logic [31:0] V_LEN [8] = '{32'd1, 32'd2, 32'd4, 32'd3, 32'd0, 32'd8, 32'd2, 32'd1};
  localparam logic [31:0] V_OFF [8] = '{32'h13, 32'h17, 32'h23, 32'h10, 32'h10, 32'h10, 32'h0D, 32'h2E};
  localparam logic [31:0] V_WIN [8] = '{32'h000000A5, 32'h0000BEEF, 32'h11223344, 32'h55667788,
                                        32'h99AABBCC, 32'hDEADBEEF, 32'h0000CAFE, 32'h0000007E};
  localparam logic        V_GO  [8] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] V_ADR [8] = '{32'h13, 32'h16, 32'h20, 0, 0, 0, 32'h0C, 32'h2E};
  localparam logic [3:0]  V_BE  [8] = '{4'b1000, 4'b1100, 4'b1111, 0, 0, 0, 4'b0011, 4'b0100};
  localparam logic [1:0]  V_SZ  [8] = '{2'd0, 2'd1, 2'd2, 0, 0, 0, 2'd1, 2'd0};
  localparam logic [31:0] V_WD  [8] = '{32'hA5000000, 32'hBEEF0000, 32'h11223344, 0, 0, 0,
                                        32'h0000CAFE, 32'h007E0000};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_req = 1'b0, cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic cfg_done, mem_req, mem_we;
  logic [7:0]  mem_bar;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  int checks = 0, errors = 0;
  int ack_lat = 0, wcnt = 0, txn_cnt = 0;
  logic [7:0]  mem_b [64];
  logic [31:0] last_addr = '0, last_wdata = '0;
  logic [3:0]  last_be = '0;
  logic [1:0]  last_size = '0;
  logic [7:0]  last_bar = '0;
  logic        last_we = 1'b0;

  always #2.5 clk = ~clk;

  cfgwin_top #(.ADDR_W(ADDR_W), .CAP_BASE(8), .BAR_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_req_i(cfg_req), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_be_i(cfg_be),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .cfg_done_o(cfg_done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_bar_o(mem_bar), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  // back-side memory model
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wcnt == ack_lat) begin
        wcnt = 0;
        mem_ack = 1'b1;
        txn_cnt++;
        last_addr = mem_addr; last_be = mem_be; last_size = mem_size;
        last_bar = mem_bar;   last_we = mem_we; last_wdata = mem_wdata;
        for (int l = 0; l < 4; l++) begin
          if (mem_we && mem_be[l]) mem_b[{mem_addr[5:2], 2'(l)}] = mem_wdata[8*l +: 8];
          mem_rdata[8*l +: 8] = mem_b[{mem_addr[5:2], 2'(l)}];
        end
      end else wcnt++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic we, input logic [5:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
    cyc = 0; rd = '0;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cfg_done) break;
    end
    rd = cfg_rdata;
    cfg_req = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] wd);
    logic [31:0] r; int c;
    cfg(1'b1, a, 4'b1111, wd, r, c);
  endtask

  task automatic rdv(input logic [5:0] a, output logic [31:0] r);
    int c;
    cfg(1'b0, a, 4'b1111, 32'h0, r, c);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int c, n0;
    for (int i = 0; i < 64; i++) mem_b[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", {31'b0, cfg_done}, 32'h0);
    check("R1 mem_req", {31'b0, mem_req}, 32'h0);
    rst_n = 1'b1;
    rdv(A_BAR, r); check("R1 bar", r, 32'h0);
    rdv(A_OFF, r); check("R1 off", r, 32'h0);
    rdv(A_LEN, r); check("R1 len", r, 32'h0);
    rdv(A_WIN, r); check("R1 win", r, 32'h0);

    // R2 field widths and byte enables
    wr(A_BAR, 32'hFFFFFFFF); rdv(A_BAR, r); check("R2 bar width", r, 32'h000000FF);
    wr(A_OFF, 32'hFFFFFFFF);
    cfg(1'b1, A_OFF, 4'b0101, 32'h0, r, c);
    rdv(A_OFF, r); check("R2 offset be", r, 32'hFF00FF00);
    wr(A_BAR, 32'h0000005A);

    // R3 outside capability
    n0 = txn_cnt;
    cfg(1'b1, 6'd2, 4'b1111, 32'h12345678, r, c); check("R3 write latency", c, 1);
    cfg(1'b0, 6'd2, 4'b1111, 32'h0, r, c);
    check("R3 read zero", r, 32'h0); check("R3 read latency", c, 1);
    check("R3 no txn", txn_cnt, n0);

    // table: window writes (R4 R6 R7 R8 R9 R10)
    for (int i = 0; i < 8; i++) begin
      ack_lat = i % 3;
      wr(A_LEN, V_LEN[i]);
      wr(A_OFF, V_OFF[i]);
      n0 = txn_cnt;
      cfg(1'b1, A_WIN, 4'b1111, V_WIN[i], r, c);
      if (V_GO[i]) begin
        check("R4 one txn", txn_cnt, n0 + 1);
        check("R4 write dir", {31'b0, last_we}, 32'h1);
        check("R7 addr", last_addr, V_ADR[i]);
        check("R7 size", {30'b0, last_size}, {30'b0, V_SZ[i]});
        check("R8 be", {28'b0, last_be}, {28'b0, V_BE[i]});
        check("R8 lanes", last_wdata & {{8{last_be[3]}}, {8{last_be[2]}}, {8{last_be[1]}}, {8{last_be[0]}}},
              V_WD[i]);
        check("R10 bar", {24'b0, last_bar}, 32'h5A);
        check("R9 latency", c, 2 + ack_lat);
      end else begin
        check("R6 no txn", txn_cnt, n0);
        check("R6 latency", c, 1);
      end
    end

    // R5 window reads
    wr(A_LEN, 32'd0);
    wr(A_WIN, 32'hDDCCBBAA);
    wr(A_LEN, 32'd2); wr(A_OFF, 32'h17);
    ack_lat = 2; n0 = txn_cnt;
    cfg(1'b0, A_WIN, 4'b1111, 32'h0, r, c);
    check("R5 half fill", r, 32'hDDCCBEEF);
    check("R5 one txn", txn_cnt, n0 + 1);
    check("R5 read dir", {31'b0, last_we}, 32'h0);
    check("R8 read be", {28'b0, last_be}, 32'hC);
    check("R9 read latency", c, 4);
    wr(A_LEN, 32'd1); wr(A_OFF, 32'h22);
    ack_lat = 0;
    cfg(1'b0, A_WIN, 4'b1111, 32'h0, r, c);
    check("R5 byte fill", r, 32'hDDCCBE22);
    check("R7 byte addr", last_addr, 32'h22);
    wr(A_LEN, 32'd4); wr(A_OFF, 32'h21);
    ack_lat = 5;
    cfg(1'b0, A_WIN, 4'b1111, 32'h0, r, c);
    check("R5 word fill", r, 32'h11223344);
    check("R9 slow ack", c, 7);

    // R6 read with unsupported length keeps window
    wr(A_LEN, 32'd5); n0 = txn_cnt;
    cfg(1'b0, A_WIN, 4'b1111, 32'h0, r, c);
    check("R6 read kept", r, 32'h11223344);
    check("R6 read no txn", txn_cnt, n0);
    check("R6 read latency", c, 1);

    // R11 byte-enable overlap
    wr(A_LEN, 32'd4); ack_lat = 1; n0 = txn_cnt;
    cfg(1'b1, A_WIN, 4'b0000, 32'hFFFFFFFF, r, c);
    check("R11 no-be no txn", txn_cnt, n0);
    check("R11 no-be latency", c, 1);
    cfg(1'b1, A_WIN, 4'b0001, 32'h000000EE, r, c);
    check("R11 partial txn", txn_cnt, n0 + 1);
    check("R11 partial data", last_wdata, 32'h112233EE);
    check("R11 partial addr", last_addr, 32'h20);
    rdv(A_WIN, r); check("R11 window kept", r, 32'h112233EE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule